// File: doc/BRIEF.md
# Codec Control Serial Write Engine

This block sends single register writes to one of two audio converter chips over a three-wire, write-only control link made of a serial data line, a serial clock line and two active-low chip selects. A client presents a chip index, a register address and a data byte with a one-cycle request. The engine assembles a fixed 16-bit frame and shifts it out most significant bit first. When the lines are idle again, it pulses a completion strobe.

Every step of the link is one interval of a programmable number of system clock cycles. The engine first holds all lines high for one interval. It then pulls the selected chip select low for one interval. Each of the 16 bits then takes three intervals: clock low, data placed, clock high. The receiver latches data on the rising clock edge. After the last bit, every line goes back high. A request with an out-of-range chip index is dropped and causes no bus activity.

Top module: `codec_ctl_writer`

## Requirements
- R1: The first eight frame bits sent are the device address 2'b10, then a constant 1, then the 5-bit register address, in that order.
- R2: The last eight frame bits are the data byte, most significant bit first. Exactly 16 rising edges of `ser_clk` occur while a select is low, and `ser_dat` is sampled on each rising edge.
- R3: Each bit spans three intervals. The clock is driven low, the data bit is placed one interval later, and the clock rises one interval after that. The first clock fall comes two intervals after acceptance, and data is stable across every rising clock edge.
- R4: For the first interval after a request is accepted, data, clock and both selects stay high. The addressed select goes low exactly one interval after acceptance.
- R5: Chip index 0 drives `sel_n[0]` low. Indices 1, 2 and 3 drive `sel_n[1]` low. The other select stays high for the whole frame, and at most one select is ever low.
- R6: When the frame ends, data, clock and both selects are all high. They stay high whenever the engine is not busy.
- R7: `busy` is high from the cycle after acceptance for exactly 50 intervals. `done` is high for exactly one cycle, the cycle in which `busy` falls.
- R8: A request whose chip index is greater than 3 is not accepted. `busy` stays low, `done` stays low and all lines stay high.
- R9: A request made while `busy` is high is ignored. The frame in progress continues unchanged, and no second frame follows.
- R10: Synchronous active-high reset drives all four link lines high, clears `busy` and `done`, and aborts any frame in progress.
- R11: One interval is exactly `STEP_CYCLES` system clock cycles.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle write request |
| req_chip | input | IDX_W (3) | Target chip index; only 0 to 3 are accepted |
| req_reg | input | REG_W (5) | Register address |
| req_data | input | DATA_W (8) | Data byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion strobe |
| ser_dat | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| sel_n | output | 2 | Active-low chip selects |

## Verification
The frame is driven with register and data values chosen to expose each kind of fault. Alternating bit patterns catch shift-order and off-by-one faults. All-ones and all-zeros bytes catch a stuck data line or a wrong constant in the header. Chip indices 0, 1 and 3 tell the two select decodes apart, and indices 4 and 7 exercise rejection. A second request in the middle of a frame, and a reset in the middle of a frame, separate the ignore rule from the abort rule. Interval positions are measured in cycles from acceptance, which exposes any wrong phase count.

// File: rtl/cw_pkg.sv
package cw_pkg;
   localparam int SEL_CNT = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_SEL,
      PH_CLK_LO,
      PH_DAT_SET,
      PH_CLK_HI
   } phase_t;
endpackage

// File: rtl/cw_step_timer.sv
module cw_step_timer #(
   parameter int STEP_CYCLES = 10000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !run) cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/cw_frame_build.sv
module cw_frame_build #(
   parameter int IDX_W   = 3,
   parameter int MAX_IDX = 3,
   parameter int DEV_W   = 2,
   parameter logic [DEV_W-1:0] DEV_ADDR = 2'b10,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 8,
   localparam int FRAME_W = DEV_W + 1 + REG_W + DATA_W
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [REG_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0] data,
   output logic [FRAME_W-1:0] frame,
   output logic [cw_pkg::SEL_CNT-1:0] sel_pick,
   output logic idx_ok
);
   assign frame  = {DEV_ADDR, 1'b1, reg_addr, data};
   assign idx_ok = (idx <= IDX_W'(MAX_IDX));

   for (genvar g = 0; g < cw_pkg::SEL_CNT; g++) begin : g_sel
      if (g == 0) begin : g_first
         assign sel_pick[g] = (idx == '0);
      end else begin : g_rest
         assign sel_pick[g] = (idx != '0);
      end
   end
endmodule

// File: rtl/cw_seq.sv
module cw_seq
   import cw_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [SEL_CNT-1:0] sel_in,
   input  logic tick,
   output logic busy,
   output logic done,
   output logic ser_dat,
   output logic ser_clk,
   output logic [SEL_CNT-1:0] sel_n
);
   localparam int BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   phase_t ph;
   logic [FRAME_W-1:0] shreg;
   logic [SEL_CNT-1:0] sel_hold;
   logic [BW-1:0] bitcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph       <= PH_IDLE;
         ser_dat  <= 1'b1;
         ser_clk  <= 1'b1;
         sel_n    <= '1;
         done     <= 1'b0;
         shreg    <= '0;
         sel_hold <= '0;
         bitcnt   <= '0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: if (start) begin
               ph       <= PH_PRE;
               shreg    <= frame_in;
               sel_hold <= sel_in;
               bitcnt   <= '0;
            end
            PH_PRE: if (tick) begin
               ph    <= PH_SEL;
               sel_n <= ~sel_hold;
            end
            PH_SEL: if (tick) begin
               ph      <= PH_CLK_LO;
               ser_clk <= 1'b0;
            end
            PH_CLK_LO: if (tick) begin
               ph      <= PH_DAT_SET;
               ser_dat <= shreg[FRAME_W-1];
               shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            end
            PH_DAT_SET: if (tick) begin
               ph      <= PH_CLK_HI;
               ser_clk <= 1'b1;
            end
            PH_CLK_HI: if (tick) begin
               if (bitcnt == LAST_BIT) begin
                  ph      <= PH_IDLE;
                  ser_dat <= 1'b1;
                  ser_clk <= 1'b1;
                  sel_n   <= '1;
                  done    <= 1'b1;
               end else begin
                  bitcnt  <= bitcnt + 1'b1;
                  ph      <= PH_CLK_LO;
                  ser_clk <= 1'b0;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy = (ph != PH_IDLE);
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer #(
   parameter int STEP_CYCLES = 10000,
   parameter int IDX_W       = 3,
   parameter int MAX_IDX     = 3,
   parameter int REG_W       = 5,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_chip,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic              ser_dat,
   output logic              ser_clk,
   output logic [1:0]        sel_n
);
   localparam int DEV_W   = 2;
   localparam int FRAME_W = DEV_W + 1 + REG_W + DATA_W;

   if (STEP_CYCLES < 1) begin : g_bad_step
      $error("STEP_CYCLES must be at least 1");
   end
   if (MAX_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("MAX_IDX does not fit in IDX_W bits");
   end
   if (cw_pkg::SEL_CNT != 2) begin : g_bad_sel
      $error("select count must match the sel_n port width");
   end

   logic [FRAME_W-1:0] frame;
   logic [1:0] sel_pick;
   logic idx_ok, tick, start;

   cw_frame_build #(
      .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .DEV_W(DEV_W),
      .DEV_ADDR(2'b10), .REG_W(REG_W), .DATA_W(DATA_W)
   ) u_frame (
      .idx(req_chip), .reg_addr(req_reg), .data(req_data),
      .frame(frame), .sel_pick(sel_pick), .idx_ok(idx_ok)
   );

   assign start = req_valid && idx_ok && !busy;

   cw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk(clk), .rst(rst), .run(busy), .tick(tick)
   );

   cw_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk(clk), .rst(rst), .start(start), .frame_in(frame),
      .sel_in(sel_pick), .tick(tick), .busy(busy), .done(done),
      .ser_dat(ser_dat), .ser_clk(ser_clk), .sel_n(sel_n)
   );
endmodule

// File: rtl/codec_ctl_writer_chk.sv
module codec_ctl_writer_chk (
   input logic       clk,
   input logic       rst,
   input logic       busy,
   input logic       done,
   input logic       ser_dat,
   input logic       ser_clk,
   input logic [1:0] sel_n
);
   // R5
   one_select_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(sel_n) >= 1);

   // R6
   idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (ser_dat && ser_clk && sel_n == 2'b11));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && ser_dat && ser_clk && sel_n == 2'b11));

   // R4
   start_high_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (ser_dat && ser_clk && sel_n == 2'b11));

   // R3
   data_setup_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(ser_clk) && busy) |-> $stable(ser_dat));
endmodule

bind codec_ctl_writer codec_ctl_writer_chk u_chk (
   .clk(clk), .rst(rst), .busy(busy), .done(done),
   .ser_dat(ser_dat), .ser_clk(ser_clk), .sel_n(sel_n)
);

// File: tb/codec_ctl_writer_test.sv
module codec_ctl_writer_test;
   localparam int T = 4;
   localparam int FRAME_CYC = 50 * T;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0;
   logic [2:0] req_chip = '0;
   logic [4:0] req_reg = '0;
   logic [7:0] req_data = '0;
   logic busy, done, ser_dat, ser_clk;
   logic [1:0] sel_n;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   codec_ctl_writer #(.STEP_CYCLES(T)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_chip(req_chip),
      .req_reg(req_reg), .req_data(req_data), .busy(busy), .done(done),
      .ser_dat(ser_dat), .ser_clk(ser_clk), .sel_n(sel_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit lines_high();
      return ser_dat === 1'b1 && ser_clk === 1'b1 && sel_n === 2'b11;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog (all R) act=%0d exp=<100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // One frame; optionally a second request mid-frame (R9)
   task automatic run_frame(input logic [2:0] idx, input logic [4:0] ra,
                            input logic [7:0] dat, input bit inject);
      int first_sel = -1, first_fall = -1, rises = 0, busy_cnt = 0;
      int done_cnt = 0, done_idx = -1;
      bit pre_ok = 1, other_low = 0, done_lines = 0;
      logic prev_clk = 1'b1;
      logic [15:0] word = '0;
      logic [15:0] expw = {2'b10, 1'b1, ra, dat};
      int want = (idx == 0) ? 0 : 1;
      @(negedge clk);
      req_valid = 1'b1; req_chip = idx; req_reg = ra; req_data = dat;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < FRAME_CYC + 6; n++) begin
         if (inject && n == 60) begin
            req_valid = 1'b1; req_chip = 3'd0; req_reg = 5'h1f; req_data = 8'h00;
         end else if (inject && n == 61) begin
            req_valid = 1'b0;
         end
         if (n < T && !lines_high()) pre_ok = 0;
         if (first_sel < 0 && sel_n !== 2'b11) first_sel = n;
         if (sel_n[1-want] === 1'b0) other_low = 1;
         if (first_fall < 0 && ser_clk === 1'b0) first_fall = n;
         if (prev_clk === 1'b0 && ser_clk === 1'b1 && sel_n !== 2'b11) begin
            rises++;
            word = {word[14:0], ser_dat};
         end
         prev_clk = ser_clk;
         if (busy === 1'b1) busy_cnt++;
         if (done === 1'b1) begin
            done_cnt++;
            done_idx = n;
            done_lines = lines_high() && busy === 1'b0;
         end
         @(negedge clk);
      end
      chk(pre_ok && first_sel == T, "R4 pre-idle/select timing", first_sel, T);
      chk(first_sel >= 0 && sel_n !== 2'b11 ? 1'b0 : !other_low, "R5 only addressed select low", other_low, 0);
      chk(first_fall == 2 * T, "R3 first clock fall", first_fall, 2 * T);
      chk(busy_cnt == FRAME_CYC, "R11 R7 busy length", busy_cnt, FRAME_CYC);
      chk(word[15:8] == expw[15:8], "R1 header byte", word[15:8], expw[15:8]);
      chk(word[7:0] == dat && rises == 16, "R2 data byte MSB first", {rises, word[7:0]}, {16, dat});
      chk(done_cnt == 1 && done_idx == FRAME_CYC, "R7 done pulse", done_idx, FRAME_CYC);
      chk(done_lines && lines_high(), "R6 lines high after frame", {ser_dat, ser_clk, sel_n}, 4'hf);
      if (inject)
         chk(word == expw && done_cnt == 1, "R9 mid-frame request ignored", word, expw);
   endtask

   task automatic reject_test(input logic [2:0] idx);
      bit ok = 1;
      @(negedge clk);
      req_valid = 1'b1; req_chip = idx; req_reg = 5'h0a; req_data = 8'h5a;
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 3 * T; n++) begin
         if (busy !== 1'b0 || done !== 1'b0 || !lines_high()) ok = 0;
         @(negedge clk);
      end
      chk(ok, "R8 out-of-range index rejected", idx, 0);
   endtask

   task automatic reset_abort_test();
      @(negedge clk);
      req_valid = 1'b1; req_chip = 3'd1; req_reg = 5'h03; req_data = 8'h81;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk(busy === 1'b1, "R10 frame running before reset", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      chk(lines_high() && busy === 1'b0 && done === 1'b0, "R10 reset aborts frame",
          {busy, done, ser_dat, ser_clk, sel_n}, 6'b001111);
      rst = 1'b0;
      repeat (3 * T) @(negedge clk);
      chk(busy === 1'b0 && lines_high(), "R10 stays idle after reset", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(lines_high() && busy === 1'b0 && done === 1'b0, "R10 reset state",
          {busy, done, ser_dat, ser_clk, sel_n}, 6'b001111);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      run_frame(3'd0, 5'h15, 8'hA5, 1'b0);
      run_frame(3'd1, 5'h0a, 8'h5A, 1'b0);
      run_frame(3'd3, 5'h1f, 8'hFF, 1'b0);
      run_frame(3'd2, 5'h00, 8'h00, 1'b1);
      reject_test(3'd4);
      reject_test(3'd7);
      reset_abort_test();
      run_frame(3'd0, 5'h01, 8'h80, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule